// File: doc/BRIEF.md
# Configurable Edge Pulse Counter

This block counts transitions on a primary pulse input and keeps the running total in a counter register. Software sets it up through a small register port. A mode field chooses one of three behaviours: idle, oversampled single-input counting, or single-input counting paced by the input's own rising edges. Control bits add a glitch-rejecting pulse-width filter, polarity inversion (count falling edges), a down-count option, and a secondary input that can flip the direction on each counted edge.

Both inputs are resynchronised into the sampling clock domain by a two-flop synchroniser before any further logic. In the edge-paced mode the filter and the inversion are bypassed, so only rising edges of the raw input advance the count.

The counter wraps at a programmable top value, and each wrap raises a sticky flag. Writes to the top value go through a buffer. The buffered value becomes the active one at the next wrap, or at once while the counter is idle. Any write to the control register clears the counter.

Top module: `edge_pulse_counter`

Register map (word addresses on `wr_addr` / `rd_addr`):
- 0: control. Bits [1:0] are the mode: 0 idle, 1 oversampled, 2 edge-paced, 3 reserved (acts as idle). Bit 2 enables the filter. Bit 3 inverts the input. Bit 4 selects down-counting. Bit 5 enables secondary-input direction control.
- 1: counter. Read only; writes are ignored.
- 2: top value. A write goes to the buffer. A read returns the active top.
- 3: flags. Bit 0 is overflow and bit 1 is underflow. Writing 1 to a bit clears it.

## Requirements
- R1: After reset the control reads 0, the counter reads 0, the active top reads all ones, and both flags are clear.
- R2: With mode 0 or mode 3, edges on the primary input leave the counter unchanged.
- R3: In mode 1 with inversion clear and filter off, every rising edge of the primary input changes the counter by exactly one, even for a 3-cycle pulse.
- R4: In mode 1 with control bit 3 set, falling edges are counted and rising edges are not.
- R5: With control bit 4 set and the secondary control off, each counted edge decrements the counter.
- R6: With control bit 5 set, a high secondary input keeps the configured direction and a low one reverses it. With bit 5 clear, the secondary input has no effect.
- R7: In mode 2, only rising edges of the primary input are counted, whatever the values of control bits 2 and 3.
- R8: In mode 1 with control bit 2 set, a change of the primary level is accepted only after it has held for 5 consecutive sampling cycles, so a 3-cycle pulse is not counted and an 8-cycle pulse is.
- R9: Counting up from the active top gives 0 and sets overflow (flags bit 0). The flag stays set through later edges.
- R10: Counting down from 0 loads the top value and sets underflow (flags bit 1).
- R11: Writing 1 to a flag bit clears that flag.
- R12: A top write made while counting leaves the active top unchanged until the next wrap. A top write made while idle takes effect at once.
- R13: Writing the control register resets the counter to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_s0 | input | 1 | Primary pulse input (asynchronous) |
| pin_s1 | input | 1 | Secondary direction input (asynchronous) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | CNT_W | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | CNT_W | Register read data (combinational) |
| ovf_flag | output | 1 | Sticky overflow flag |
| unf_flag | output | 1 | Sticky underflow flag |

## Verification
The primary input is driven with long clean pulses, with 3-cycle glitches and with held levels. The first two separate filtered from unfiltered paths. The held levels separate rising-edge from falling-edge counting, because the count is checked between the two halves of each pulse. Each mode is also run with the secondary input held high and then low, and with it ignored, so that direction reversal is not confused with the down bit. Small top values force both wrap directions, and top writes made while counting expose whether the buffer holds them back until the wrap.

// File: rtl/epc_pkg.sv
package epc_pkg;

    typedef enum logic [1:0] {
        MODE_OFF = 2'd0,
        MODE_OVS = 2'd1,
        MODE_EXT = 2'd2,
        MODE_RSV = 2'd3
    } mode_e;

    typedef struct packed {
        logic  sec_dir;
        logic  down;
        logic  invert;
        logic  filt;
        mode_e mode;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    localparam logic [1:0] ADDR_CTRL  = 2'd0;
    localparam logic [1:0] ADDR_CNT   = 2'd1;
    localparam logic [1:0] ADDR_TOP   = 2'd2;
    localparam logic [1:0] ADDR_FLAGS = 2'd3;

endpackage

// File: rtl/epc_sync.sv
module epc_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= din;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/epc_filter.sv
module epc_filter #(
    parameter int LEN = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_lvl,
    output logic out_lvl
);
    localparam int CW = $clog2(LEN + 1);

    typedef struct packed {
        logic          lvl;
        logic [CW-1:0] run;
    } filt_st_t;

    filt_st_t q, d;

    always_comb begin
        d = q;
        if (in_lvl == q.lvl) begin
            d.run = '0;
        end else if (q.run == CW'(LEN - 1)) begin
            d.lvl = in_lvl;
            d.run = '0;
        end else begin
            d.run = q.run + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign out_lvl = q.lvl;

    // R8: output never moves while the input agrees with it
    a_r8_filter_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (in_lvl == q.lvl) |=> $stable(q.lvl));
endmodule

// File: rtl/edge_pulse_counter.sv
module edge_pulse_counter
    import epc_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int FILT_LEN = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_s0,
    input  logic             pin_s1,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    output logic [CNT_W-1:0] rd_data,
    output logic             ovf_flag,
    output logic             unf_flag
);
    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] top;
        logic [CNT_W-1:0] top_buf;
        logic             prev;
        logic             ovf;
        logic             unf;
    } st_t;

    st_t q, d;

    logic [1:0] sync_out;
    logic       s0_sync, s1_sync, s0_filt;

    epc_sync #(.W(2), .STAGES(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({pin_s1, pin_s0}),
        .dout (sync_out)
    );
    assign s0_sync = sync_out[0];
    assign s1_sync = sync_out[1];

    epc_filter #(.LEN(FILT_LEN)) u_filt (
        .clk    (clk),
        .rst_n  (rst_n),
        .in_lvl (s0_sync),
        .out_lvl(s0_filt)
    );

    ctrl_t new_ctrl;
    logic  ctrl_wr, active, lvl, new_lvl, edge_hit, count_up;

    assign new_ctrl = ctrl_t'(wr_data[CTRL_W-1:0]);
    assign ctrl_wr  = wr_en && (wr_addr == ADDR_CTRL);
    assign active   = (q.ctrl.mode == MODE_OVS) || (q.ctrl.mode == MODE_EXT);

    always_comb begin
        if (q.ctrl.mode == MODE_EXT) lvl = s0_sync;
        else lvl = (q.ctrl.filt ? s0_filt : s0_sync) ^ q.ctrl.invert;
        if (new_ctrl.mode == MODE_EXT) new_lvl = s0_sync;
        else new_lvl = (new_ctrl.filt ? s0_filt : s0_sync) ^ new_ctrl.invert;
    end

    assign edge_hit = active && lvl && !q.prev && !ctrl_wr;
    assign count_up = !q.ctrl.down ^ (q.ctrl.sec_dir && !s1_sync);

    always_comb begin
        d      = q;
        d.prev = ctrl_wr ? new_lvl : lvl;

        if (wr_en && wr_addr == ADDR_TOP) d.top_buf = wr_data;
        if (!active) d.top = q.top_buf;

        if (wr_en && wr_addr == ADDR_FLAGS) begin
            if (wr_data[0]) d.ovf = 1'b0;
            if (wr_data[1]) d.unf = 1'b0;
        end

        if (edge_hit) begin
            if (count_up) begin
                if (q.cnt == q.top) begin
                    d.cnt = '0;
                    d.top = q.top_buf;
                    d.ovf = 1'b1;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end else begin
                if (q.cnt == '0) begin
                    d.cnt = q.top_buf;
                    d.top = q.top_buf;
                    d.unf = 1'b1;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
        end

        if (ctrl_wr) begin
            d.ctrl = new_ctrl;
            d.cnt  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q         <= '0;
            q.top     <= '1;
            q.top_buf <= '1;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        case (rd_addr)
            ADDR_CTRL: rd_data = CNT_W'(q.ctrl);
            ADDR_CNT:  rd_data = q.cnt;
            ADDR_TOP:  rd_data = q.top;
            default:   rd_data = CNT_W'({q.unf, q.ovf});
        endcase
    end

    assign ovf_flag = q.ovf;
    assign unf_flag = q.unf;

    // R9: a fresh overflow leaves the counter at zero
    a_r9_ovf_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> (q.cnt == '0));

    // R10: a fresh underflow leaves the counter at the active top
    a_r10_unf_load: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unf_flag) |-> (q.cnt == q.top));

    // R2: an idle counter holds its value unless control is written
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !ctrl_wr) |=> $stable(q.cnt));

    // R12: while counting, the active top moves only on a counted edge
    a_r12_top_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !edge_hit) |=> $stable(q.top));
endmodule

// File: tb/edge_pulse_counter_bench.sv
module edge_pulse_counter_bench;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             pin_s0 = 1'b0, pin_s1 = 1'b0;
    logic             wr_en = 1'b0;
    logic [1:0]       wr_addr = '0, rd_addr = '0;
    logic [CNT_W-1:0] wr_data = '0;
    logic [CNT_W-1:0] rd_data;
    logic             ovf_flag, unf_flag;

    int n_run = 0, n_fail = 0;

    always #5 clk = ~clk;

    edge_pulse_counter #(.CNT_W(CNT_W), .FILT_LEN(5)) u_edge_pulse_counter (
        .clk(clk), .rst_n(rst_n), .pin_s0(pin_s0), .pin_s1(pin_s1),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .ovf_flag(ovf_flag), .unf_flag(unf_flag)
    );

    task automatic chk(input string req, input logic [CNT_W-1:0] got, input logic [CNT_W-1:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [CNT_W-1:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic rd(input logic [1:0] a, output logic [CNT_W-1:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic pulse(input int hi, input int lo);
        pin_s0 = 1'b1;
        repeat (hi) @(negedge clk);
        pin_s0 = 1'b0;
        repeat (lo) @(negedge clk);
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) pulse(8, 8);
    endtask

    task automatic t_reset;
        logic [CNT_W-1:0] v;
        rd(0, v); chk("R1 ctrl", v, 0);
        rd(1, v); chk("R1 cnt", v, 0);
        rd(2, v); chk("R1 top", v, '1);
        rd(3, v); chk("R1 flags", v, 0);
    endtask

    task automatic t_disabled;
        logic [CNT_W-1:0] v;
        wr(0, 16'h0000); pulses(3);
        rd(1, v); chk("R2 mode0", v, 0);
        wr(0, 16'h0003); pulses(3);
        rd(1, v); chk("R2 mode3", v, 0);
    endtask

    task automatic t_ovs_up;
        logic [CNT_W-1:0] v;
        wr(0, 16'h0001); pulses(3);
        pulse(3, 8);
        rd(1, v); chk("R3 rising count", v, 4);
        wr(0, 16'h0001);
        rd(1, v); chk("R13 ctrl write clears", v, 0);
    endtask

    task automatic t_invert;
        logic [CNT_W-1:0] v;
        wr(0, 16'h0009);
        pin_s0 = 1'b1; repeat (8) @(negedge clk);
        rd(1, v); chk("R4 rising ignored", v, 0);
        pin_s0 = 1'b0; repeat (8) @(negedge clk);
        rd(1, v); chk("R4 falling counted", v, 1);
    endtask

    task automatic t_down_underflow;
        logic [CNT_W-1:0] v;
        wr(0, 16'h0000); wr(2, 9);
        wr(0, 16'h0011); pulses(1);
        rd(1, v); chk("R10 underflow loads top", v, 9);
        rd(3, v); chk("R10 underflow flag", v, 2);
        pulses(2);
        rd(1, v); chk("R5 down count", v, 7);
        wr(3, 2);
        rd(3, v); chk("R11 clear underflow", v, 0);
    endtask

    task automatic t_secdir;
        logic [CNT_W-1:0] v;
        pin_s1 = 1'b1;
        wr(0, 16'h0021); pulses(3);
        rd(1, v); chk("R6 s1 high up", v, 3);
        pin_s1 = 1'b0; repeat (4) @(negedge clk);
        pulses(1);
        rd(1, v); chk("R6 s1 low reverses", v, 2);
        wr(0, 16'h0001); pulses(2);
        rd(1, v); chk("R6 s1 ignored when off", v, 2);
        pin_s1 = 1'b1;
    endtask

    task automatic t_ext;
        logic [CNT_W-1:0] v;
        wr(0, 16'h000E);
        pin_s0 = 1'b1; repeat (8) @(negedge clk);
        rd(1, v); chk("R7 rising counted", v, 1);
        pin_s0 = 1'b0; repeat (8) @(negedge clk);
        rd(1, v); chk("R7 falling ignored", v, 1);
        pulse(3, 8);
        rd(1, v); chk("R7 filter bypassed", v, 2);
    endtask

    task automatic t_filter;
        logic [CNT_W-1:0] v;
        wr(0, 16'h0005);
        repeat (8) @(negedge clk);
        pulse(3, 10);
        rd(1, v); chk("R8 short pulse rejected", v, 0);
        pulse(8, 10);
        rd(1, v); chk("R8 long pulse counted", v, 1);
    endtask

    task automatic t_overflow;
        logic [CNT_W-1:0] v;
        wr(0, 16'h0000); wr(2, 2);
        wr(0, 16'h0001); pulses(2);
        rd(1, v); chk("R9 below top", v, 2);
        pulses(1);
        rd(1, v); chk("R9 wrap to zero", v, 0);
        rd(3, v); chk("R9 overflow flag", v, 1);
        pulses(1);
        rd(3, v); chk("R9 flag sticky", v, 1);
        wr(3, 1);
        rd(3, v); chk("R11 clear overflow", v, 0);
    endtask

    task automatic t_topbuf;
        logic [CNT_W-1:0] v;
        wr(0, 16'h0000); wr(2, 3);
        rd(2, v); chk("R12 idle write immediate", v, 3);
        wr(0, 16'h0001); wr(2, 5);
        rd(2, v); chk("R12 held while counting", v, 3);
        pulses(4);
        rd(1, v); chk("R12 wrap at old top", v, 0);
        rd(2, v); chk("R12 new top after wrap", v, 5);
        pulses(5);
        rd(1, v); chk("R12 counts to new top", v, 5);
        wr(3, 3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_ovs_up();
        t_invert();
        t_down_underflow();
        t_secdir();
        t_ext();
        t_filter();
        t_overflow();
        t_topbuf();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule